// File: doc/BRIEF.md
# Timer Unit Register Front-End

This block puts two or three down-counting timer channels behind one small register window. A bus master reads and writes 32-bit words through a single-cycle port. The window holds an output control bit, a shared run register with one bit per channel, and one register bank per channel. Each bank holds a reload value, the live count, a control word and, on the last channel of the three-channel build, a capture register. Each channel raises its own interrupt line.

Two build options shape the window. `THREE_CH` selects three channels instead of two, and only the third channel can capture. `EXT_OPT` adds the output control bit and lets channels count edges of two outside clock inputs. An access the current build cannot honour is refused with a one-cycle error pulse. This covers an absent or unmapped word, a misaligned address, a run bit for a missing channel, and a reserved control value. A refused write changes nothing.

Top module: `tmu_regfront`

## Requirements
- R1: After reset every reload and count register reads 0xFFFFFFFF, the run register, the control words and the output control bit read 0, and the error and interrupt outputs are low.
- R2: Word offsets decode as follows: 0x00 output control, 0x04 run register, and bank k at 0x08+12k holding reload (+0), count (+4) and control (+8). The capture register of the capturing channel sits at 0x2C. A read returns the stored value on the cycle after the request.
- R3: The output control register keeps only bit 0 and drives `pin_ctrl_o` from it. Without `EXT_OPT` offset 0x00 is refused.
- R4: Run register bit k lets channel k count, and bits above the channel count read as 0. A channel whose bit is clear holds its count.
- R5: An unmapped or misaligned access raises `bus_err_o` for exactly the cycle after the request, returns read data 0 and changes no register.
- R6: In the two-channel build a run write with bit 2 set is refused and leaves the run register unchanged, and every offset from 0x20 upward is refused.
- R7: Control bits [2:0] = n (0..4) make the channel count once per 4^(n+1) clock cycles, with the first step 4^(n+1) cycles after the run bit is written. A step from count 0 loads the reload value and sets the underflow flag (control bit 8).
- R8: With control bit 5 set, `irq_o[k]` rises one cycle after the underflow flag sets. Writing the control word with bit 8 = 0 clears the flag, and the line falls one cycle later.
- R9: A control write is refused (error, word unchanged) when it holds any of the following: prescale code 5, a nonzero bit in [15:10], or capture code 1 in bits [7:6]. Capture codes 2 and 3, or bit 9 set, are refused on a channel that cannot capture. Prescale codes 6 or 7, or a nonzero edge field in bits [4:3], are refused without `EXT_OPT`.
- R10: Prescale code 7 counts edges of `ext_clk_i` and code 6 counts edges of `slow_clk_i`. The edge field selects rising (0), falling (1) or both (2, 3).
- R11: On the capturing channel, capture code 2 or 3 copies the count into the capture register on a rising edge of `cap_i` and sets control bit 9. Code 3 also drives the interrupt. With capture code 0 the capture register is untouched.
- R12: A write to a count register loads that value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte offset in the window |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the cycle after a read |
| bus_err_o | output | 1 | One-cycle pulse for a refused access |
| ext_clk_i | input | 1 | Outside count clock (prescale code 7) |
| slow_clk_i | input | 1 | Slow count clock (prescale code 6) |
| cap_i | input | 1 | Capture trigger for the capturing channel |
| pin_ctrl_o | output | 1 | Output control bit |
| irq_o | output | NCH | One interrupt line per channel |

## Verification
A wrong decode shows at once: the read one cycle after the request returns another register's value or raises an error it should not. A prescaler that restarts at the wrong time, or divides by the wrong ratio, moves the first count step off its 4^(n+1) cycle slot. Reading the count on two neighbouring edges around that slot exposes it. A flag or interrupt-enable fault shows on `irq_o` exactly one cycle after the underflow or capture, or after the clearing write.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  // what an address resolves to
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_OCR   = 2'd1,
    TGT_START = 2'd2,
    TGT_CHAN  = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] ch;
    logic [1:0] sub;   // 0 reload, 1 count, 2 control, 3 capture
  } hit_t;

  // stored part of a channel control word (bits 7:0)
  typedef struct packed {
    logic [1:0] capm;  // capture mode
    logic       unie;  // underflow interrupt enable
    logic [1:0] edg;   // edge select for outside clocks
    logic [2:0] psc;   // prescale / source code
  } ctrl_t;

  localparam int OCR_OFS     = 0;
  localparam int START_OFS   = 4;
  localparam int BANK_BASE   = 8;
  localparam int BANK_STRIDE = 12;
  localparam int FLAG_UNF    = 8;
  localparam int FLAG_CAP    = 9;
  localparam logic [2:0] PSC_SLOW = 3'd6;
  localparam logic [2:0] PSC_EXT  = 3'd7;

endpackage

// File: rtl/tmu_decode.sv
module tmu_decode import tmu_pkg::*; #(
  parameter int AW     = 8,
  parameter int NCH    = 3,
  parameter bit CAP_EN = 1'b1,
  parameter bit OCR_EN = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output hit_t          hit_o
);
  localparam int CAP_OFS = BANK_BASE + BANK_STRIDE * NCH;

  always_comb begin
    hit_o = '{tgt: TGT_NONE, ch: 2'd0, sub: 2'd0};
    if (addr_i[1:0] == 2'b00) begin
      if (OCR_EN && addr_i == AW'(OCR_OFS)) begin
        hit_o.tgt = TGT_OCR;
      end else if (addr_i == AW'(START_OFS)) begin
        hit_o.tgt = TGT_START;
      end else if (CAP_EN && addr_i == AW'(CAP_OFS)) begin
        hit_o.tgt = TGT_CHAN;
        hit_o.ch  = 2'(NCH - 1);
        hit_o.sub = 2'd3;
      end else begin
        for (int k = 0; k < NCH; k++) begin
          if (addr_i >= AW'(BANK_BASE + BANK_STRIDE * k) &&
              addr_i <  AW'(BANK_BASE + BANK_STRIDE * (k + 1))) begin
            hit_o.tgt = TGT_CHAN;
            hit_o.ch  = 2'(k);
            hit_o.sub = 2'((addr_i - AW'(BANK_BASE + BANK_STRIDE * k)) >> 2);
          end
        end
      end
    end
  end

endmodule

// File: rtl/tmu_channel.sv
module tmu_channel import tmu_pkg::*; #(
  parameter int DW     = 32,
  parameter int NDIV   = 5,
  parameter bit CAP_EN = 1'b0,
  parameter bit EXT_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [1:0]    sub_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_clk_i,
  input  logic          slow_clk_i,
  input  logic          cap_i,
  output logic [DW-1:0] rdata_o,
  output logic          bad_o,
  output logic          irq_o
);
  localparam int PW = 2 * NDIV;

  logic [DW-1:0] reload_q, count_q, cap_q;
  ctrl_t         ctrl_q, ctrl_w;
  logic          unf_q, capf_q, irq_q, cap_prev;
  logic [PW-1:0] pre_q;
  logic          wr_reload, wr_cnt, wr_ctrl, wr_cap, ctrl_bad;
  logic          tick_div, tick_ext, tick, step, unf_evt, cap_evt;

  assign ctrl_w = ctrl_t'(wdata_i[7:0]);

  // reserved control encodings
  always_comb begin
    ctrl_bad = 1'b0;
    if (ctrl_w.psc >= 3'(NDIV) && ctrl_w.psc < PSC_SLOW) ctrl_bad = 1'b1;
    if (!EXT_EN && (ctrl_w.psc >= PSC_SLOW || ctrl_w.edg != 2'd0)) ctrl_bad = 1'b1;
    if (ctrl_w.capm == 2'b01) ctrl_bad = 1'b1;
    if (!CAP_EN && (ctrl_w.capm != 2'b00 || wdata_i[FLAG_CAP])) ctrl_bad = 1'b1;
    if (|wdata_i[15:10]) ctrl_bad = 1'b1;
  end

  assign bad_o     = sel_i && wr_i && (sub_i == 2'd2) && ctrl_bad;
  assign wr_reload = sel_i && wr_i && (sub_i == 2'd0);
  assign wr_cnt    = sel_i && wr_i && (sub_i == 2'd1);
  assign wr_ctrl   = sel_i && wr_i && (sub_i == 2'd2) && !ctrl_bad;
  assign wr_cap    = CAP_EN && sel_i && wr_i && (sub_i == 2'd3);

  // internal prescale tap for the selected ratio
  always_comb begin
    tick_div = 1'b0;
    for (int d = 0; d < NDIV; d++) begin
      if (ctrl_q.psc == 3'(d))
        tick_div = ((pre_q & PW'((1 << (2 * d + 2)) - 1)) == PW'((1 << (2 * d + 2)) - 1));
    end
  end

  generate
    if (EXT_EN) begin : g_ext
      logic ext_prev, slow_prev, src, src_prev, rise, fall;
      always_ff @(posedge clk) begin
        if (rst) begin
          ext_prev  <= 1'b0;
          slow_prev <= 1'b0;
        end else begin
          ext_prev  <= ext_clk_i;
          slow_prev <= slow_clk_i;
        end
      end
      assign src      = (ctrl_q.psc == PSC_EXT) ? ext_clk_i : slow_clk_i;
      assign src_prev = (ctrl_q.psc == PSC_EXT) ? ext_prev  : slow_prev;
      assign rise     = src && !src_prev;
      assign fall     = !src && src_prev;
      assign tick_ext = (ctrl_q.edg == 2'd0) ? rise :
                        (ctrl_q.edg == 2'd1) ? fall : (rise || fall);
    end else begin : g_noext
      assign tick_ext = 1'b0;
    end
  endgenerate

  assign tick    = (ctrl_q.psc >= PSC_SLOW) ? tick_ext : tick_div;
  assign step    = run_i && tick && !wr_cnt;
  assign unf_evt = step && (count_q == '0);
  assign cap_evt = CAP_EN && ctrl_q.capm[1] && cap_i && !cap_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      cap_q    <= '0;
      ctrl_q   <= '0;
      unf_q    <= 1'b0;
      capf_q   <= 1'b0;
      irq_q    <= 1'b0;
      cap_prev <= 1'b0;
      pre_q    <= '0;
    end else begin
      cap_prev <= cap_i;
      if (wr_reload) reload_q <= wdata_i;
      if (wr_ctrl)   ctrl_q   <= ctrl_w;
      pre_q <= (!run_i || wr_ctrl) ? '0 : pre_q + PW'(1);
      if (wr_cnt)       count_q <= wdata_i;
      else if (unf_evt) count_q <= reload_q;
      else if (step)    count_q <= count_q - DW'(1);
      unf_q  <= (unf_q && !(wr_ctrl && !wdata_i[FLAG_UNF])) || unf_evt;
      capf_q <= (capf_q && !(wr_ctrl && !wdata_i[FLAG_CAP])) || cap_evt;
      if (cap_evt)     cap_q <= count_q;
      else if (wr_cap) cap_q <= wdata_i;
      irq_q <= (unf_q && ctrl_q.unie) || (capf_q && ctrl_q.capm == 2'b11);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    case (sub_i)
      2'd0: rdata_o = reload_q;
      2'd1: rdata_o = count_q;
      2'd2: begin
        rdata_o[7:0]      = ctrl_q;
        rdata_o[FLAG_UNF] = unf_q;
        rdata_o[FLAG_CAP] = capf_q;
      end
      default: rdata_o = CAP_EN ? cap_q : '0;
    endcase
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_cnt) |=> $stable(count_q)); // R4
  AST_RELOAD_ON_UNF: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick && count_q == '0 && !wr_cnt) |=> (count_q == $past(reload_q) && unf_q)); // R7
  AST_IRQ_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    (unf_q && ctrl_q.unie) |=> irq_o); // R8
  AST_CTRL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.psc >= 3'(NDIV) && ctrl_q.psc < PSC_SLOW) && ctrl_q.capm != 2'b01); // R9

  generate
    if (!CAP_EN) begin : g_nocap_chk
      AST_NO_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (rst)
        !capf_q); // R11
    end
  endgenerate

endmodule

// File: rtl/tmu_regfront.sv
module tmu_regfront import tmu_pkg::*; #(
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int THREE_CH = 1,
  parameter int EXT_OPT  = 1,
  parameter int NDIV     = 5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  bus_sel_i,
  input  logic                                  bus_wr_i,
  input  logic [AW-1:0]                         bus_addr_i,
  input  logic [DW-1:0]                         bus_wdata_i,
  output logic [DW-1:0]                         bus_rdata_o,
  output logic                                  bus_err_o,
  input  logic                                  ext_clk_i,
  input  logic                                  slow_clk_i,
  input  logic                                  cap_i,
  output logic                                  pin_ctrl_o,
  output logic [((THREE_CH != 0) ? 3 : 2)-1:0]  irq_o
);
  localparam int NCH   = (THREE_CH != 0) ? 3 : 2;
  localparam int MAXCH = 3;
  localparam logic [MAXCH-1:0] CH_MASK = MAXCH'((1 << NCH) - 1);

  hit_t             hit;
  logic [MAXCH-1:0] start_q;
  logic             ocr_q, err_q, err_n, start_ill, wr_ok;
  logic [DW-1:0]    rdata_q, rd_mux;
  logic [NCH-1:0]   ch_sel, ch_bad, ch_irq;
  logic [DW-1:0]    ch_rd [NCH];

  tmu_decode #(
    .AW(AW), .NCH(NCH), .CAP_EN(THREE_CH != 0), .OCR_EN(EXT_OPT != 0)
  ) u_decode (
    .addr_i(bus_addr_i),
    .hit_o (hit)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_sel[k] = bus_sel_i && (hit.tgt == TGT_CHAN) && (hit.ch == 2'(k));
    tmu_channel #(
      .DW(DW), .NDIV(NDIV),
      .CAP_EN((THREE_CH != 0) && (k == NCH - 1)),
      .EXT_EN(EXT_OPT != 0)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .run_i     (start_q[k]),
      .sel_i     (ch_sel[k]),
      .wr_i      (bus_wr_i),
      .sub_i     (hit.sub),
      .wdata_i   (bus_wdata_i),
      .ext_clk_i (ext_clk_i),
      .slow_clk_i(slow_clk_i),
      .cap_i     (cap_i),
      .rdata_o   (ch_rd[k]),
      .bad_o     (ch_bad[k]),
      .irq_o     (ch_irq[k])
    );
  end

  assign start_ill = |(bus_wdata_i[MAXCH-1:0] & ~CH_MASK);
  assign err_n = bus_sel_i && ((hit.tgt == TGT_NONE) ||
                 (bus_wr_i && hit.tgt == TGT_START && start_ill) ||
                 (|ch_bad));
  assign wr_ok = bus_sel_i && bus_wr_i && !err_n;

  always_comb begin
    rd_mux = '0;
    case (hit.tgt)
      TGT_OCR:   rd_mux[0] = ocr_q;
      TGT_START: rd_mux[MAXCH-1:0] = start_q;
      TGT_CHAN: begin
        for (int k = 0; k < NCH; k++)
          if (hit.ch == 2'(k)) rd_mux = ch_rd[k];
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      ocr_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= err_n;
      rdata_q <= (bus_sel_i && !bus_wr_i && !err_n) ? rd_mux : '0;
      if (wr_ok && hit.tgt == TGT_OCR)   ocr_q   <= bus_wdata_i[0];
      if (wr_ok && hit.tgt == TGT_START) start_q <= bus_wdata_i[MAXCH-1:0];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;
  assign pin_ctrl_o  = ocr_q;
  assign irq_o       = ch_irq;

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_sel_i) |-> !bus_err_o); // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    bus_err_o |-> (bus_rdata_o == '0)); // R5

  generate
    if (NCH < MAXCH) begin : g_lite_chk
      AST_NO_MISSING_RUN: assert property (@(posedge clk) disable iff (rst)
        start_q[MAXCH-1] == 1'b0); // R6
    end
  endgenerate

endmodule

// File: tb/test_tmu_regfront.sv
module test_tmu_regfront;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, sel_l = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ext = 1'b0, slow = 1'b0, cap = 1'b0;
  logic [31:0] rdata, rdata_l;
  logic        err, err_l, pin, pin_l;
  logic [2:0]  irq;
  logic [1:0]  irq_l;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmu_regfront i_tmu_regfront (
    .clk(clk), .rst(rst), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err),
    .ext_clk_i(ext), .slow_clk_i(slow), .cap_i(cap),
    .pin_ctrl_o(pin), .irq_o(irq));

  tmu_regfront #(.THREE_CH(0), .EXT_OPT(0)) i_tmu_regfront_lite (
    .clk(clk), .rst(rst), .bus_sel_i(sel_l), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_l), .bus_err_o(err_l),
    .ext_clk_i(ext), .slow_clk_i(slow), .cap_i(cap),
    .pin_ctrl_o(pin_l), .irq_o(irq_l));

  typedef struct packed {
    logic [3:0]  rq;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  1'b0, 8'h0C, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1 count
    '{4'd1,  1'b0, 8'h08, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1 reload
    '{4'd1,  1'b0, 8'h04, 32'h0,        32'h0,        1'b0}, // R1 run reg
    '{4'd2,  1'b1, 8'h08, 32'h12345678, 32'h0,        1'b0}, // R2
    '{4'd2,  1'b0, 8'h08, 32'h0,        32'h12345678, 1'b0}, // R2
    '{4'd12, 1'b1, 8'h18, 32'h0000ABCD, 32'h0,        1'b0}, // R12
    '{4'd12, 1'b0, 8'h18, 32'h0,        32'h0000ABCD, 1'b0}, // R12
    '{4'd3,  1'b1, 8'h00, 32'hFFFFFFFF, 32'h0,        1'b0}, // R3
    '{4'd3,  1'b0, 8'h00, 32'h0,        32'h1,        1'b0}, // R3
    '{4'd2,  1'b1, 8'h2C, 32'h0000BEEF, 32'h0,        1'b0}, // R2 capture reg
    '{4'd2,  1'b0, 8'h2C, 32'h0,        32'h0000BEEF, 1'b0}, // R2
    '{4'd5,  1'b0, 8'h30, 32'h0,        32'h0,        1'b1}, // R5 unmapped
    '{4'd5,  1'b0, 8'h06, 32'h0,        32'h0,        1'b1}, // R5 misaligned
    '{4'd9,  1'b1, 8'h10, 32'h5,        32'h0,        1'b1}, // R9 prescale 5
    '{4'd9,  1'b0, 8'h10, 32'h0,        32'h0,        1'b0}, // R9 unchanged
    '{4'd2,  1'b1, 8'h28, 32'hA3,       32'h0,        1'b0}, // R2
    '{4'd2,  1'b0, 8'h28, 32'h0,        32'hA3,       1'b0}, // R2
    '{4'd9,  1'b1, 8'h1C, 32'h40,       32'h0,        1'b1}, // R9 capture code 1
    '{4'd9,  1'b1, 8'h1C, 32'h80,       32'h0,        1'b1}, // R9 no capture on ch1
    '{4'd9,  1'b0, 8'h1C, 32'h0,        32'h0,        1'b0}, // R9
    '{4'd4,  1'b1, 8'h04, 32'hF8,       32'h0,        1'b0}, // R4 upper bits
    '{4'd4,  1'b0, 8'h04, 32'h0,        32'h0,        1'b0}, // R4
    '{4'd9,  1'b1, 8'h10, 32'h400,      32'h0,        1'b1}  // R9 bits 15:10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic acc(input bit lite, input bit w, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic er);
    sel = !lite; sel_l = lite; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    rd = lite ? rdata_l : rdata;
    er = lite ? err_l : err;
    sel = 1'b0; sel_l = 1'b0; wr = 1'b0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext = 1'b1; repeat (2) @(negedge clk);
      ext = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      slow = 1'b1; repeat (2) @(negedge clk);
      slow = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic ext_case(input logic [1:0] edg, input int n, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 1, 8'h10, 32'(7 | (edg << 3)), rd, er);
    acc(0, 1, 8'h0C, 32'd10, rd, er);
    acc(0, 1, 8'h04, 32'h1, rd, er);
    pulse_ext(n);
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    chk("R10 outside clock edge count", rd, exp);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, rd2;
    logic        er;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 err after reset", 32'(err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(0, VEC[i].wr, VEC[i].addr, VEC[i].wd, rd, er);
      chk($sformatf("R%0d table data %0d", VEC[i].rq, i), rd, VEC[i].exp);
      chk($sformatf("R%0d table err %0d", VEC[i].rq, i), 32'(er), 32'(VEC[i].err));
    end
    chk("R3 pin follows bit 0", 32'(pin), 32'h1);

    // R7 / R8: divide by 4, underflow and interrupt timing
    acc(0, 1, 8'h08, 32'd5, rd, er);
    acc(0, 1, 8'h0C, 32'd2, rd, er);
    acc(0, 1, 8'h10, 32'h20, rd, er);
    acc(0, 1, 8'h04, 32'h1, rd, er);
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R8 irq low before underflow", 32'(irq[0]), 32'h0);
    @(negedge clk);
    chk("R8 irq low on flag cycle", 32'(irq[0]), 32'h0);
    @(negedge clk);
    chk("R8 irq high one cycle after flag", 32'(irq[0]), 32'h1);
    acc(0, 0, 8'h10, 32'h0, rd, er);
    chk("R7 underflow flag bit 8", rd, 32'h120);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    chk("R7 reload after underflow", rd, 32'd5);
    acc(0, 1, 8'h10, 32'h20, rd, er);
    @(negedge clk);
    chk("R8 irq falls after clear", 32'(irq[0]), 32'h0);

    // R4: stopped channel holds
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    repeat (20) @(negedge clk);
    acc(0, 0, 8'h0C, 32'h0, rd2, er);
    chk("R4 stopped count holds", rd2, rd);

    // R7: divide by 16, first step exactly 16 cycles after start
    acc(0, 1, 8'h1C, 32'h1, rd, er);
    acc(0, 1, 8'h18, 32'd3, rd, er);
    acc(0, 1, 8'h04, 32'h2, rd, er);
    repeat (15) @(posedge clk);
    @(negedge clk);
    acc(0, 0, 8'h18, 32'h0, rd, er);
    chk("R7 div16 before first step", rd, 32'd3);
    acc(0, 0, 8'h18, 32'h0, rd, er);
    chk("R7 div16 first step", rd, 32'd2);
    acc(0, 1, 8'h04, 32'h0, rd, er);

    // R10: outside clocks
    ext_case(2'd0, 3, 32'd7);
    ext_case(2'd1, 2, 32'd8);
    ext_case(2'd2, 3, 32'd4);
    acc(0, 1, 8'h10, 32'h6, rd, er);
    acc(0, 1, 8'h0C, 32'd10, rd, er);
    acc(0, 1, 8'h04, 32'h1, rd, er);
    pulse_slow(4);
    acc(0, 1, 8'h04, 32'h0, rd, er);
    acc(0, 0, 8'h0C, 32'h0, rd, er);
    chk("R10 slow clock rising count", rd, 32'd6);

    // R11: capture on channel 2
    acc(0, 1, 8'h28, 32'hC7, rd, er);
    acc(0, 1, 8'h24, 32'h55, rd, er);
    cap = 1'b1; repeat (2) @(negedge clk);
    cap = 1'b0; repeat (2) @(negedge clk);
    acc(0, 0, 8'h2C, 32'h0, rd, er);
    chk("R11 captured count", rd, 32'h55);
    acc(0, 0, 8'h28, 32'h0, rd, er);
    chk("R11 capture flag bit 9", rd, 32'h2C7);
    chk("R11 capture interrupt", 32'(irq[2]), 32'h1);
    acc(0, 1, 8'h28, 32'hC7, rd, er);
    @(negedge clk);
    chk("R11 capture interrupt cleared", 32'(irq[2]), 32'h0);
    acc(0, 1, 8'h28, 32'h07, rd, er);
    acc(0, 1, 8'h24, 32'h66, rd, er);
    cap = 1'b1; repeat (2) @(negedge clk);
    cap = 1'b0; repeat (2) @(negedge clk);
    acc(0, 0, 8'h2C, 32'h0, rd, er);
    chk("R11 no capture when off", rd, 32'h55);

    // R6 / R3 / R9 on the two-channel build without outside clocks
    acc(1, 1, 8'h04, 32'h4, rd, er);
    chk("R6 run bit 2 refused", 32'(er), 32'h1);
    acc(1, 0, 8'h04, 32'h0, rd, er);
    chk("R6 run register unchanged", rd, 32'h0);
    acc(1, 1, 8'h04, 32'h3, rd, er);
    chk("R4 lite run write accepted", 32'(er), 32'h0);
    acc(1, 0, 8'h04, 32'h0, rd, er);
    chk("R4 lite run readback", rd, 32'h3);
    acc(1, 0, 8'h20, 32'h0, rd, er);
    chk("R6 offset 0x20 refused", 32'(er), 32'h1);
    acc(1, 0, 8'h00, 32'h0, rd, er);
    chk("R3 output control absent", 32'(er), 32'h1);
    acc(1, 1, 8'h10, 32'h6, rd, er);
    chk("R9 slow source needs option", 32'(er), 32'h1);
    acc(1, 1, 8'h10, 32'h8, rd, er);
    chk("R9 edge field needs option", 32'(er), 32'h1);
    acc(1, 0, 8'h10, 32'h0, rd, er);
    chk("R9 lite control unchanged", rd, 32'h0);
    chk("R3 lite pin low", 32'(pin_l), 32'h0);
    acc(1, 1, 8'h04, 32'h0, rd, er);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule